// File: doc/BRIEF.md
# Clock-Multiplier Loop Control Register

This block is the digital control and status logic that sits next to a clock-multiplying phase-locked loop. Software writes one 16-bit control word that holds an encoded feedback ratio (M), an encoded reference ratio (N), four loop-filter trim bits, a power-up bit and a clock-select bit. The block decodes the two codes into the true divider ratios, passes the trim bits and the power-up bit straight to the analog loop, and raises the select line toward the core clock multiplexer only when the loop is powered and known to be locked. The loop then runs its oscillator at input × M / N, and the core clock is half of that.

The lock indication from the analog loop is asynchronous. It is brought into the register clock domain through a synchronizer chain and then captured in a sticky status flag. Every write to the control word clears that flag, so software must see it set again before it trusts the new settings. Writes that would disturb the dividers at an unsafe moment, or that carry an M code outside the usable range, are refused as a whole and leave a sticky error flag behind.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset every control field is zero, so `m_ratio` is 2, `n_ratio` is 2, `loop_filter` is 0, `pll_pwr_en` and `pll_clk_sel` are 0, and `rd_data` reads 0x0000.
- R2: The control word places the N code in bits [2:0], the M code in bits [7:3], the loop-filter bits in [11:8], the power-up bit in bit 12 and the select bit in bit 13; `m_ratio` equals the M code plus 2.
- R3: `n_ratio` is 1 when the N code is 3'b111 and the N code plus 2 for every other code.
- R4: `loop_filter` mirrors bits [11:8] of the stored word and `pll_pwr_en` mirrors the stored power-up bit.
- R5: The lock flag, read in `rd_data` bit 14, is set only while the power-up bit is set and only once `lock_async` has passed a two-stage synchronizer: a rise of `lock_async` before clock edge k shows in the flag after edge k+2 and not earlier; once set, the flag stays set when `lock_async` falls.
- R6: Every write, accepted or refused, clears the lock flag on its edge; a write outranks a lock that arrives in the same cycle.
- R7: A write that changes the M or N code while the stored select bit is 1 is refused: the whole stored word stays as it was.
- R8: A write that changes the M or N code and clears the power-up bit while it is stored as 1 is refused.
- R9: A write whose M code is above 18 (ratio above 20) is refused.
- R10: A refused write sets the error flag, read in `rd_data` bit 15; it stays set until an accepted write with bit 15 set clears it.
- R11: `pll_clk_sel` is 1 exactly when the stored select bit, the stored power-up bit and the lock flag are all 1, and drops in the same cycle any of them clears.
- R12: Bits 14 and 15 of a write never set the lock or error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| lock_async | input | 1 | Lock indication from the analog loop, asynchronous |
| rd_data | output | 16 | Stored control word with lock (bit 14) and error (bit 15) flags |
| m_ratio | output | 5 | Decoded feedback ratio, 2 to 20 |
| n_ratio | output | 4 | Decoded reference ratio, 1 to 8 |
| loop_filter | output | 4 | Loop-filter trim bits for the analog loop |
| pll_pwr_en | output | 1 | Loop power-up control |
| pll_clk_sel | output | 1 | Select for the loop-derived core clock |

## Verification
The lock flag can be set by the synchronized lock input and cleared by a register write in one and the same cycle, and the write must win. The bench holds `lock_async` high long enough that the synchronizer output is steady, then issues a write and checks that the flag and `pll_clk_sel` read 0 right after that edge and come back one edge later. A refused write and an error-clearing write bit can also meet in one write; the bench sends a refused word with bit 15 set and checks that the error flag stays set.

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs #(
  parameter int SYNC_STAGES = 2,
  parameter int M_CODE_MAX  = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        lock_async,
  output logic [15:0] rd_data,
  output logic [4:0]  m_ratio,
  output logic [3:0]  n_ratio,
  output logic [3:0]  loop_filter,
  output logic        pll_pwr_en,
  output logic        pll_clk_sel
);

  logic [2:0] n_code;
  logic [4:0] m_code;
  logic [3:0] lf_q;
  logic       en_q, sel_q, lock_q, err_q;
  logic [SYNC_STAGES-1:0] sync_q;

  logic [2:0] wr_n;
  logic [4:0] wr_m;
  logic       div_change, unsafe, bad_m, refuse;

  assign wr_n = wr_data[2:0];
  assign wr_m = wr_data[7:3];

  assign div_change = (wr_n != n_code) || (wr_m != m_code);
  assign unsafe     = div_change && (sel_q || (en_q && !wr_data[12]));
  assign bad_m      = wr_m > 5'(M_CODE_MAX);
  assign refuse     = wr_en && (unsafe || bad_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_code <= '0;
      m_code <= '0;
      lf_q   <= '0;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else if (wr_en && !refuse) begin
      n_code <= wr_n;
      m_code <= wr_m;
      lf_q   <= wr_data[11:8];
      en_q   <= wr_data[12];
      sel_q  <= wr_data[13];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], lock_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           lock_q <= 1'b0;
    else if (wr_en)                       lock_q <= 1'b0;
    else if (en_q && sync_q[SYNC_STAGES-1]) lock_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    err_q <= 1'b0;
    else if (refuse)               err_q <= 1'b1;
    else if (wr_en && wr_data[15]) err_q <= 1'b0;
  end

  assign m_ratio     = m_code + 5'd2;
  assign n_ratio     = (n_code == 3'b111) ? 4'd1 : {1'b0, n_code} + 4'd2;
  assign loop_filter = lf_q;
  assign pll_pwr_en  = en_q;
  assign pll_clk_sel = sel_q && en_q && lock_q;
  assign rd_data     = {err_q, lock_q, sel_q, en_q, lf_q, m_code, n_code};

endmodule

module pll_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        lock_async,
  input logic [15:0] rd_data,
  input logic [4:0]  m_ratio,
  input logic [3:0]  n_ratio,
  input logic        pll_pwr_en,
  input logic        pll_clk_sel
);

  assert_m_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_ratio >= 5'd2 && m_ratio <= 5'd20);

  assert_n_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    n_ratio >= 4'd1 && n_ratio <= 4'd8);

  assert_lock_via_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[14]) |-> $past(lock_async, 3));

  assert_write_clears_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_data[14]);

  assert_div_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[13]) |=> ($stable(m_ratio) && $stable(n_ratio)));

  assert_bad_m_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7:3] > 5'd18) |=> rd_data[15]);

  assert_sel_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pll_clk_sel |-> (pll_pwr_en && rd_data[14] && rd_data[13]));

endmodule

bind pll_ctrl_regs pll_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .lock_async(lock_async), .rd_data(rd_data), .m_ratio(m_ratio),
  .n_ratio(n_ratio), .pll_pwr_en(pll_pwr_en), .pll_clk_sel(pll_clk_sel)
);

// File: tb/pll_ctrl_regs_bench.sv
module pll_ctrl_regs_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        lock_async = 1'b0;
  logic [15:0] rd_data;
  logic [4:0]  m_ratio;
  logic [3:0]  n_ratio;
  logic [3:0]  loop_filter;
  logic        pll_pwr_en;
  logic        pll_clk_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctrl_regs u_pll_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lock_async(lock_async), .rd_data(rd_data), .m_ratio(m_ratio),
    .n_ratio(n_ratio), .loop_filter(loop_filter), .pll_pwr_en(pll_pwr_en),
    .pll_clk_sel(pll_clk_sel)
  );

  // entry: {write word, expected rd_data, expected m_ratio, expected n_ratio}
  localparam logic [40:0] VEC [NVEC] = '{
    {16'h0307, 16'h0307, 5'd2,  4'd1},  // R3 code 7 -> 1
    {16'h1A96, 16'h1A96, 5'd20, 4'd8},  // R2 top M, R3 code 6 -> 8
    {16'h1128, 16'h1128, 5'd7,  4'd2},  // R2/R3 N code 0 -> 2
    {16'h1198, 16'h9128, 5'd7,  4'd2},  // R9 M code 19 refused
    {16'h9128, 16'h1128, 5'd7,  4'd2},  // R10 accepted with bit 15 clears
    {16'h0128, 16'h0128, 5'd7,  4'd2},  // R8 power-down, dividers kept
    {16'h3053, 16'h3053, 5'd12, 4'd5},  // select+power from idle accepted
    {16'h305B, 16'hB053, 5'd12, 4'd5},  // R7 M change while selected
    {16'h1F53, 16'h9F53, 5'd12, 4'd5},  // deselect, same dividers; err kept
    {16'h0054, 16'h9F53, 5'd12, 4'd5},  // R8 N change with power-down
    {16'h9054, 16'h1054, 5'd12, 4'd6},  // R10 clear, N change accepted
    {16'h5054, 16'h1054, 5'd12, 4'd6},  // R12 bit 14 written
    {16'h90FC, 16'h9054, 5'd12, 4'd6}   // R9 code 31, R10 refusal beats clear
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 m_ratio", {11'd0, m_ratio}, 16'd2);
    check("R1 n_ratio", {12'd0, n_ratio}, 16'd2);
    check("R1 outputs", {12'd0, loop_filter}, 16'd0);
    check("R1 sel/pwr", {14'd0, pll_clk_sel, pll_pwr_en}, 16'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][40:25]);
      check($sformatf("R2/R7-R10 vector %0d rd_data", i), rd_data, VEC[i][24:9]);
      check($sformatf("R2 vector %0d m_ratio", i), {11'd0, m_ratio}, {11'd0, VEC[i][8:4]});
      check($sformatf("R3 vector %0d n_ratio", i), {12'd0, n_ratio}, {12'd0, VEC[i][3:0]});
      check($sformatf("R4 vector %0d filter/pwr", i), {11'd0, pll_pwr_en, loop_filter},
            {11'd0, VEC[i][24-3], VEC[i][20:17]});
    end

    // R5: lock passes a two-stage synchronizer, only while powered
    do_write(16'h3053);
    lock_async = 1'b1;
    @(negedge clk);
    check("R5 after edge 1", {15'd0, rd_data[14]}, 16'd0);
    @(negedge clk);
    check("R5 after edge 2", {15'd0, rd_data[14]}, 16'd0);
    check("R11 sel before lock", {15'd0, pll_clk_sel}, 16'd0);
    @(negedge clk);
    check("R5 after edge 3", {15'd0, rd_data[14]}, 16'd1);
    check("R11 sel with lock", {15'd0, pll_clk_sel}, 16'd1);

    // R6: write and steady lock in same cycle, write wins
    do_write(16'h3053);
    check("R6 write clears lock", {15'd0, rd_data[14]}, 16'd0);
    check("R11 sel drops with lock", {15'd0, pll_clk_sel}, 16'd0);
    @(negedge clk);
    check("R6 lock returns", {15'd0, rd_data[14]}, 16'd1);

    // R5: sticky after lock input falls
    lock_async = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 sticky", {15'd0, rd_data[14]}, 16'd1);

    // R11: clearing select drops the mux select at once
    do_write(16'h1053);
    check("R11 deselect", {15'd0, pll_clk_sel}, 16'd0);

    // R5: no lock while powered down
    do_write(16'h0053);
    lock_async = 1'b1;
    repeat (5) @(negedge clk);
    check("R5 unpowered no lock", {15'd0, rd_data[14]}, 16'd0);
    check("R4 power down", {15'd0, pll_pwr_en}, 16'd0);

    // R12: written flag bits do not set flags
    do_write(16'hC053);
    check("R12 flag bits ignored", rd_data, 16'h0053);

    // R1: reset mid-run returns to zero
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", rd_data, 16'h0000);
    finish_run();
  end
endmodule